// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds two component predictors. The first is a table of 2-bit counters indexed by a shift register that records the outcomes of the most recent branches, whatever their address. The second works per branch in two levels. A table indexed by branch address holds the recent outcome pattern of that one branch, and that pattern then indexes a table of 3-bit counters. A third table of 2-bit saturating counters, indexed by branch address, picks which of the two components supplies the final answer for that branch.

The fetch side presents a branch address and receives the final direction together with both component guesses in the same cycle. Later, when the branch resolves, the back end returns the address, the real outcome and the two component guesses that were made for it. That single update trains both components, moves the chooser when the components disagreed, and shifts the real outcome into both history registers. Every table size and counter width is a parameter. Default sizes give 4K chooser counters, 4K global counters, 1K local histories of 10 bits and 1K local counters of 3 bits, about 29 Kbits of state.

Top module: `tourney_dir_pred`

## Requirements
- R1: After reset every history is zero, every global and chooser counter holds 1, every local counter holds 3. For any address, pred_global, pred_local and pred_taken are therefore 0.
- R2: The predict port is combinational: outputs for pred_pc reflect the state left by all updates accepted at earlier clock edges, and an update accepted at an edge is visible to predictions from the following cycle on.
- R3: pred_global is 1 exactly when the global counter selected by the current global history value is 2 or more. On an update, that same counter (indexed by the history as it stands before the shift) moves one step toward the actual outcome.
- R4: pred_local is 1 exactly when the 3-bit local counter selected by the local history of the branch is 4 or more. The local history is taken from address bits [PC_LSB +: LHT_IDX_W]. On an update, the counter selected by that branch's pre-update history moves one step toward the outcome.
- R5: pred_taken equals pred_global when the chooser counter at address bits [PC_LSB +: SEL_IDX_W] is 2 or more, and pred_local otherwise.
- R6: On an update with upd_global_pred different from upd_local_pred, the chooser counter moves up by one if the global guess matched upd_taken, and down by one otherwise. When the two guesses are equal, it is left unchanged.
- R7: On every update, the global history and the local history entry of the branch shift left by one, with upd_taken entering bit 0 and the oldest bit dropped.
- R8: While upd_valid is 0, no counter or history changes, whatever the other update inputs carry.
- R9: All counters saturate. 2-bit counters stay within 0..3 and 3-bit counters within 0..7. A step past an end leaves the value at that end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_pc | input | PC_W | Address of the branch being predicted |
| pred_taken | output | 1 | Final direction (1 = taken) |
| pred_global | output | 1 | Guess of the global-history component |
| pred_local | output | 1 | Guess of the local-history component |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome (1 = taken) |
| upd_global_pred | input | 1 | Global guess that was made for this branch |
| upd_local_pred | input | 1 | Local guess that was made for this branch |

## Verification
All three prediction outputs are due in the same cycle as pred_pc, so the bench changes the address in the low phase of the clock and samples one time unit later, well before the next rising edge. An update is taken at the rising edge where upd_valid is high, and its effect is due from the next cycle. The bench therefore advances its arithmetic model only after that edge and then sweeps every index of a small configuration before the following edge. Checks are tagged with the requirement whose phase (reset, correlated stream, alternation, loop, saturation, idle inputs, mixed addresses) drives them.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

   typedef enum logic {
      PICK_LOCAL  = 1'b0,
      PICK_GLOBAL = 1'b1
   } pick_e;

   // Weakly-not-taken value of a W-bit counter: one below its midpoint.
   function automatic int weak_nt(input int w);
      return (1 << (w - 1)) - 1;
   endfunction

   // The chooser only learns when the two components disagree.
   function automatic logic chooser_moves(input logic g_guess, input logic l_guess);
      return g_guess ^ l_guess;
   endfunction

endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table #(
   parameter int IDX_W = 12,
   parameter int CTR_W = 2,
   parameter int INIT  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_taken,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_up
);
   localparam int             DEPTH  = 1 << IDX_W;
   localparam logic [CTR_W-1:0] C_MAX  = '1;
   localparam logic [CTR_W-1:0] C_INIT = CTR_W'(INIT);
   localparam logic [CTR_W-1:0] C_ONE  = CTR_W'(1);

   if (CTR_W < 1 || CTR_W > 8) begin : g_bad_width
      $error("tbp_ctr_table: CTR_W out of range");
   end
   if (INIT < 0 || INIT >= (1 << CTR_W)) begin : g_bad_init
      $error("tbp_ctr_table: INIT does not fit CTR_W");
   end

   logic [CTR_W-1:0] ctr_q [DEPTH];
   logic [CTR_W-1:0] cur_val;
   logic [CTR_W-1:0] nxt_val;

   assign cur_val = ctr_q[wr_idx];

   always_comb begin
      nxt_val = cur_val;
      if (wr_up) begin
         if (cur_val != C_MAX) nxt_val = cur_val + C_ONE;
      end else begin
         if (cur_val != '0) nxt_val = cur_val - C_ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) ctr_q[i] <= C_INIT;
      end else if (wr_en) begin
         ctr_q[wr_idx] <= nxt_val;
      end
   end

   // Upper half of the range means taken (or, for the chooser, global).
   assign rd_taken = ctr_q[rd_idx][CTR_W-1];

endmodule

// File: rtl/tbp_hist_table.sv
module tbp_hist_table #(
   parameter int IDX_W  = 10,
   parameter int HIST_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [HIST_W-1:0] rd_hist,
   input  logic [IDX_W-1:0]  up_idx,
   output logic [HIST_W-1:0] up_hist,
   input  logic              wr_en,
   input  logic              wr_bit
);
   localparam int DEPTH = 1 << IDX_W;

   if (HIST_W < 1) begin : g_bad_hist
      $error("tbp_hist_table: HIST_W must be at least 1");
   end

   logic [HIST_W-1:0] hist_q [DEPTH];
   logic [HIST_W-1:0] shifted;

   assign rd_hist = hist_q[rd_idx];
   assign up_hist = hist_q[up_idx];

   if (HIST_W == 1) begin : g_one_bit
      assign shifted = wr_bit;
   end else begin : g_multi_bit
      assign shifted = {up_hist[HIST_W-2:0], wr_bit};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
      end else if (wr_en) begin
         hist_q[up_idx] <= shifted;
      end
   end

endmodule

// File: rtl/tourney_dir_pred.sv
module tourney_dir_pred
   import tbp_pkg::*;
#(
   parameter int PC_W      = 32,
   parameter int PC_LSB    = 2,
   parameter int SEL_IDX_W = 12,
   parameter int SEL_W     = 2,
   parameter int GHIST_W   = 12,
   parameter int GCTR_W    = 2,
   parameter int LHT_IDX_W = 10,
   parameter int LHIST_W   = 10,
   parameter int LCTR_W    = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] pred_pc,
   output logic            pred_taken,
   output logic            pred_global,
   output logic            pred_local,
   input  logic            upd_valid,
   input  logic [PC_W-1:0] upd_pc,
   input  logic            upd_taken,
   input  logic            upd_global_pred,
   input  logic            upd_local_pred
);
   localparam int SEL_INIT = weak_nt(SEL_W);
   localparam int GCTR_INIT = weak_nt(GCTR_W);
   localparam int LCTR_INIT = weak_nt(LCTR_W);

   if (PC_LSB + SEL_IDX_W > PC_W) begin : g_bad_sel_idx
      $error("tourney_dir_pred: chooser index exceeds PC width");
   end
   if (PC_LSB + LHT_IDX_W > PC_W) begin : g_bad_lht_idx
      $error("tourney_dir_pred: local history index exceeds PC width");
   end
   if (SEL_W < 2 || GCTR_W < 2 || LCTR_W < 2) begin : g_bad_ctr
      $error("tourney_dir_pred: counters need at least 2 bits for hysteresis");
   end
   if (GHIST_W < 1) begin : g_bad_ghist
      $error("tourney_dir_pred: GHIST_W must be at least 1");
   end

   logic [SEL_IDX_W-1:0] sel_idx_p, sel_idx_u;
   logic [LHT_IDX_W-1:0] lht_idx_p, lht_idx_u;
   logic [LHIST_W-1:0]   lhist_p, lhist_u;
   logic [GHIST_W-1:0]   ghist_q, ghist_nxt;
   logic                 sel_global;
   logic                 g_guess, l_guess;
   pick_e                pick;
   logic                 unused_pc_bits;

   assign sel_idx_p = pred_pc[PC_LSB +: SEL_IDX_W];
   assign sel_idx_u = upd_pc[PC_LSB +: SEL_IDX_W];
   assign lht_idx_p = pred_pc[PC_LSB +: LHT_IDX_W];
   assign lht_idx_u = upd_pc[PC_LSB +: LHT_IDX_W];
   assign unused_pc_bits = ^{pred_pc, upd_pc};

   // Global history register: newest outcome enters at bit 0.
   if (GHIST_W == 1) begin : g_gh_one
      assign ghist_nxt = upd_taken;
   end else begin : g_gh_multi
      assign ghist_nxt = {ghist_q[GHIST_W-2:0], upd_taken};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ghist_q <= '0;
      else if (upd_valid) ghist_q <= ghist_nxt;
   end

   tbp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(GCTR_W), .INIT(GCTR_INIT)) u_gtab (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (ghist_q),
      .rd_taken (g_guess),
      .wr_en    (upd_valid),
      .wr_idx   (ghist_q),
      .wr_up    (upd_taken)
   );

   tbp_hist_table #(.IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) u_lht (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (lht_idx_p),
      .rd_hist (lhist_p),
      .up_idx  (lht_idx_u),
      .up_hist (lhist_u),
      .wr_en   (upd_valid),
      .wr_bit  (upd_taken)
   );

   tbp_ctr_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W), .INIT(LCTR_INIT)) u_ltab (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (lhist_p),
      .rd_taken (l_guess),
      .wr_en    (upd_valid),
      .wr_idx   (lhist_u),
      .wr_up    (upd_taken)
   );

   tbp_ctr_table #(.IDX_W(SEL_IDX_W), .CTR_W(SEL_W), .INIT(SEL_INIT)) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (sel_idx_p),
      .rd_taken (sel_global),
      .wr_en    (upd_valid && chooser_moves(upd_global_pred, upd_local_pred)),
      .wr_idx   (sel_idx_u),
      .wr_up    (upd_global_pred == upd_taken)
   );

   assign pick        = pick_e'(sel_global);
   assign pred_global = g_guess;
   assign pred_local  = l_guess;
   assign pred_taken  = (pick == PICK_GLOBAL) ? g_guess : l_guess;

endmodule

// File: rtl/tbp_checker.sv
module tbp_checker #(
   parameter int PC_W    = 32,
   parameter int GHIST_W = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic [PC_W-1:0]    pred_pc,
   input logic               pred_taken,
   input logic               pred_global,
   input logic               pred_local,
   input logic               upd_valid,
   input logic               upd_taken,
   input logic [GHIST_W-1:0] ghist
);

   // R1: first cycle out of reset predicts not-taken on every path
   a_r1_reset_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!pred_taken && !pred_global && !pred_local));

   // R5: when both components agree, the final answer cannot differ
   a_r5_agree_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_global == pred_local) |-> (pred_taken == pred_global));

   // R7: the resolved outcome lands in the newest global history bit
   a_r7_newest_bit: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |=> (ghist[0] == $past(upd_taken)));

   // R8: no update, no history movement
   a_r8_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_valid |=> $stable(ghist));

   // R8: no update and same address, same predictions
   a_r8_pred_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(upd_valid) && $stable(pred_pc))
         |-> $stable({pred_taken, pred_global, pred_local}));

endmodule

bind tourney_dir_pred tbp_checker #(.PC_W(PC_W), .GHIST_W(GHIST_W)) u_tbp_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pred_pc     (pred_pc),
   .pred_taken  (pred_taken),
   .pred_global (pred_global),
   .pred_local  (pred_local),
   .upd_valid   (upd_valid),
   .upd_taken   (upd_taken),
   .ghist       (ghist_q)
);

// File: tb/tb_tourney_dir_pred.sv
module tb_tourney_dir_pred;
   localparam int PCW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [PCW-1:0] pred_pc = '0;
   logic [PCW-1:0] upd_pc = '0;
   logic upd_valid = 1'b0, upd_taken = 1'b0, upd_gp = 1'b0, upd_lp = 1'b0;
   logic pred_taken, pred_global, pred_local;

   tourney_dir_pred #(
      .PC_W(PCW), .PC_LSB(0), .SEL_IDX_W(3), .SEL_W(2), .GHIST_W(3),
      .GCTR_W(2), .LHT_IDX_W(2), .LHIST_W(3), .LCTR_W(3)
   ) dut (
      .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
      .pred_global(pred_global), .pred_local(pred_local), .upd_valid(upd_valid),
      .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_global_pred(upd_gp),
      .upd_local_pred(upd_lp)
   );

   int n_tests = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   // Arithmetic model of the small configuration
   int m_ch[8];
   int m_gc[8];
   int m_lc[8];
   int m_lht[4];
   int m_gh;

   function automatic int sat(input int v, input bit up, input int mx);
      if (up) return (v < mx) ? v + 1 : v;
      return (v > 0) ? v - 1 : v;
   endfunction

   function automatic bit mg();
      return m_gc[m_gh] >= 2;
   endfunction

   function automatic bit ml(input int pc);
      return m_lc[m_lht[pc % 4]] >= 4;
   endfunction

   function automatic bit mf(input int pc);
      return (m_ch[pc % 8] >= 2) ? mg() : ml(pc);
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 8; i++) begin
         m_ch[i] = 1; m_gc[i] = 1; m_lc[i] = 3;
      end
      for (int i = 0; i < 4; i++) m_lht[i] = 0;
      m_gh = 0;
   endtask

   task automatic model_update(input int pc, input bit t);
      bit g, l;
      int i;
      g = mg();
      l = ml(pc);
      i = pc % 4;
      if (g != l) m_ch[pc % 8] = sat(m_ch[pc % 8], g == t, 3);
      m_gc[m_gh] = sat(m_gc[m_gh], t, 3);
      m_lc[m_lht[i]] = sat(m_lc[m_lht[i]], t, 7);
      m_lht[i] = ((m_lht[i] << 1) | int'(t)) & 7;
      m_gh = ((m_gh << 1) | int'(t)) & 7;
   endtask

   task automatic chk(input string tag, input string what, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
      end
   endtask

   // Looks at every index of the small tables; needs 8 ns, run in one half period.
   task automatic sweep(input string tag);
      for (int pc = 0; pc < 8; pc++) begin
         pred_pc = PCW'(pc);
         #1;
         chk({tag, "/R3"}, "pred_global", pred_global, mg());
         chk({tag, "/R4"}, "pred_local", pred_local, ml(pc));
         chk({tag, "/R5"}, "pred_taken", pred_taken, mf(pc));
      end
   endtask

   task automatic step(input int pc, input bit t, input string tag);
      @(negedge clk);
      pred_pc = PCW'(pc);
      #1;
      chk(tag, "pred_taken", pred_taken, mf(pc));
      upd_valid = 1'b1;
      upd_pc = PCW'(pc);
      upd_taken = t;
      upd_gp = mg();
      upd_lp = ml(pc);
      @(posedge clk);
      model_update(pc, t);
      #1;
      upd_valid = 1'b0;
      sweep({tag, "/R2"});
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      upd_valid = 1'b0;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
   endtask

   initial begin
      logic [15:0] lf;
      bit prev;
      do_reset();
      sweep("R1");

      // Correlated stream over several addresses (global history, R7)
      prev = 1'b0;
      for (int k = 0; k < 200; k++) begin
         prev = (k % 8 == 0) ? 1'b1 : (prev ^ (k % 3 == 0));
         step(k % 8, prev, "R7");
      end

      // One branch alternating: local history learns it (R4)
      for (int k = 0; k < 40; k++) step(6, k[0], "R4");

      // Loop shape on one branch: three taken then one not taken (R6)
      for (int k = 0; k < 60; k++) step(3, (k % 4) != 3, "R6");

      // Saturation at the top then descent (R9)
      for (int k = 0; k < 15; k++) step(5, 1'b1, "R9");
      for (int k = 0; k < 10; k++) step(5, 1'b0, "R9");

      // Mixed addresses above the index width, pseudo-random outcomes (R5)
      lf = 16'hACE1;
      for (int k = 0; k < 1500; k++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         step(int'(lf[7:0]), lf[9] | lf[11], "R5");
      end

      // Update fields toggle without upd_valid: nothing may change (R8)
      for (int k = 0; k < 30; k++) begin
         @(negedge clk);
         upd_pc = PCW'(k * 37);
         upd_taken = k[0];
         upd_gp = k[1];
         upd_lp = ~k[1];
         pred_pc = PCW'(k);
      end
      @(negedge clk);
      sweep("R8");

      // Reset in mid-run restores the initial state (R1)
      do_reset();
      sweep("R1");

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule